// File: doc/BRIEF.md
# Boot-Persistent Event Mode Selector

This block decides, one boot at a time, whether general purpose events are handled by the legacy path or delivered as exposed GPIO-style interrupts. Software that can service exposed interrupts announces this by raising a request strobe at some point during each boot. The block remembers that announcement in a pending-mode bit. That bit survives boot pulses and is cleared only by a cold reset. It also holds the mode that is active for the current boot.

A change of mode never takes effect within the boot in which it is requested. A request moves the pending mode to exposed at once, and the next boot pulse makes it active. Every boot pulse copies the pending mode into the active mode. It then re-arms the pending mode from whether a request was seen in the boot that just ended. As a result, once software stops asking, the block returns to legacy only after two further boot pulses. While exposed mode is active, the legacy-handling enable is held low.

Top module: `evt_mode_sel`

## Requirements
- R1: While the cold reset input coldRstN is low, and immediately after it goes low, activeMode and pendingMode read 0 (legacy), legacyEn reads 1 and modeChange reads 0. This holds whatever history came before the reset.
- R2: A cycle with supportReq high and bootPulse low sets pendingMode to 1 (exposed) after that clock edge and leaves activeMode unchanged.
- R3: A cycle with bootPulse low never changes activeMode. On a cycle with bootPulse high, activeMode takes the pendingMode value held before that edge.
- R4: On a cycle with bootPulse high, pendingMode becomes 1 if supportReq was high in any cycle since the previous boot pulse, or in the pulse cycle itself. Otherwise it becomes 0.
- R5: supportReq high in the same cycle as bootPulse counts toward the boot that begins with that pulse, not the boot that ends.
- R6: legacyEn is always the inverse of activeMode, so legacy handling is off whenever exposed mode (1) is active.
- R7: modeChange is 1 exactly when pendingMode differs from activeMode.
- R8: Starting from exposed mode active, if no further request arrives, activeMode stays 1 after the first boot pulse and returns to 0 after the second.
- R9: Boot pulses with no request since cold reset keep activeMode at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| coldRstN | input | 1 | Asynchronous active-low cold reset; clears all state |
| bootPulse | input | 1 | One-cycle marker of a boot boundary |
| supportReq | input | 1 | Software announcement that exposed mode is supported |
| activeMode | output | 1 | Mode of the current boot: 0 legacy, 1 exposed |
| pendingMode | output | 1 | Mode that the next boot pulse will make active |
| legacyEn | output | 1 | Legacy event handling enable |
| modeChange | output | 1 | Pending mode differs from active mode |

## Verification
The block has no parameters, so the bench builds the single configuration in which every state is one bit. That brings every reachable combination of request-seen, pending and active state within reach of a short vector walk. The walk covers the entry into exposed mode and the two-boot exit. It also covers a request that arrives in the same cycle as the boot pulse, and back-to-back boot pulses. Directed tests apply a cold reset while exposed mode is both active and pending.

// File: rtl/evt_mode_pkg.sv
package evt_mode_pkg;

  typedef enum logic {
    MODE_LEGACY  = 1'b0,
    MODE_EXPOSED = 1'b1
  } evtMode_t;

  typedef struct packed {
    logic bootEdge;   // boot boundary: load active, re-arm pending, restart seen
    logic reqHit;     // support request observed this cycle
  } modeStrobes_t;

endpackage

// File: rtl/evt_mode_ctrl.sv
module evt_mode_ctrl
  import evt_mode_pkg::*;
(
  input  logic         clk,
  input  logic         coldRstN,
  input  logic         bootPulse,
  input  logic         supportReq,
  output modeStrobes_t strobes
);

  always_comb begin
    strobes.bootEdge = bootPulse;
    strobes.reqHit   = supportReq;
  end

  // R2: a request outside a boot pulse must arm the exposed mode.
  assert_req_arms_R2: assert property (@(posedge clk) disable iff (!coldRstN)
    (supportReq && !bootPulse) |-> (strobes.reqHit && !strobes.bootEdge));

endmodule

// File: rtl/evt_mode_dp.sv
module evt_mode_dp
  import evt_mode_pkg::*;
(
  input  logic         clk,
  input  logic         coldRstN,
  input  modeStrobes_t strobes,
  output evtMode_t     activeQ,
  output evtMode_t     pendingQ
);

  logic seenQ;

  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      seenQ    <= 1'b0;
      pendingQ <= MODE_LEGACY;
      activeQ  <= MODE_LEGACY;
    end else if (strobes.bootEdge) begin
      activeQ  <= pendingQ;
      pendingQ <= evtMode_t'(seenQ | strobes.reqHit);
      seenQ    <= strobes.reqHit;
    end else begin
      seenQ <= seenQ | strobes.reqHit;
      if (strobes.reqHit) pendingQ <= MODE_EXPOSED;
    end
  end

  assert_req_sets_pending_R2: assert property (@(posedge clk) disable iff (!coldRstN)
    (strobes.reqHit && !strobes.bootEdge) |=> (pendingQ == MODE_EXPOSED));

  assert_active_stable_R3: assert property (@(posedge clk) disable iff (!coldRstN)
    !strobes.bootEdge |=> $stable(activeQ));

  assert_active_loads_R3: assert property (@(posedge clk) disable iff (!coldRstN)
    strobes.bootEdge |=> (activeQ == $past(pendingQ)));

  assert_pending_rearm_R4: assert property (@(posedge clk) disable iff (!coldRstN)
    strobes.bootEdge |=> (pendingQ == evtMode_t'($past(seenQ) | $past(strobes.reqHit))));

endmodule

// File: rtl/evt_mode_sel.sv
module evt_mode_sel
  import evt_mode_pkg::*;
(
  input  logic clk,
  input  logic coldRstN,
  input  logic bootPulse,
  input  logic supportReq,
  output logic activeMode,
  output logic pendingMode,
  output logic legacyEn,
  output logic modeChange
);

  modeStrobes_t strobes;
  evtMode_t     activeQ;
  evtMode_t     pendingQ;

  evt_mode_ctrl i_ctrl (
    .clk        (clk),
    .coldRstN   (coldRstN),
    .bootPulse  (bootPulse),
    .supportReq (supportReq),
    .strobes    (strobes)
  );

  evt_mode_dp i_dp (
    .clk      (clk),
    .coldRstN (coldRstN),
    .strobes  (strobes),
    .activeQ  (activeQ),
    .pendingQ (pendingQ)
  );

  always_comb begin
    activeMode  = (activeQ == MODE_EXPOSED);
    pendingMode = (pendingQ == MODE_EXPOSED);
    legacyEn    = (activeQ == MODE_LEGACY);
    modeChange  = (activeQ != pendingQ);
  end

  // R1: immediately after cold reset the block reports legacy.
  assert_cold_legacy_R1: assert property (@(posedge clk)
    !coldRstN |-> (!activeMode && !pendingMode && legacyEn));

endmodule

// File: tb/test_evt_mode_sel.sv
module test_evt_mode_sel;

  logic clk = 1'b0;
  logic coldRstN = 1'b0;
  logic bootPulse = 1'b0;
  logic supportReq = 1'b0;
  logic activeMode, pendingMode, legacyEn, modeChange;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_mode_sel i_evt_mode_sel (
    .clk(clk), .coldRstN(coldRstN), .bootPulse(bootPulse), .supportReq(supportReq),
    .activeMode(activeMode), .pendingMode(pendingMode),
    .legacyEn(legacyEn), .modeChange(modeChange)
  );

  // {boot, req, expActive, expPending}
  localparam int NVEC = 14;
  localparam logic [3:0] VECS [NVEC] = '{
    4'b00_00,  // idle after reset
    4'b10_00,  // R9 boot with no history
    4'b01_01,  // R2 request arms pending
    4'b00_01,  // R2 active unchanged
    4'b10_11,  // R3 R4 boot enters exposed
    4'b00_11,
    4'b10_10,  // R8 first boot without request
    4'b00_10,
    4'b10_00,  // R8 second boot returns to legacy
    4'b01_01,
    4'b11_11,  // R5 request in pulse cycle
    4'b10_11,  // R5 counted for the new boot
    4'b10_10,
    4'b10_00
  };

  task automatic check(string req, logic act, logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic checkAll(string req, logic expA, logic expP);
    check({req, " activeMode"}, activeMode, expA);
    check({req, " pendingMode"}, pendingMode, expP);
    check("R6 legacyEn", legacyEn, ~expA);
    check("R7 modeChange", modeChange, expA ^ expP);
  endtask

  initial begin
    #100000;
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    #1;
    checkAll("R1 reset", 1'b0, 1'b0);
    @(negedge clk); @(negedge clk);
    coldRstN = 1'b1;
    @(negedge clk);
    checkAll("R1 released", 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      bootPulse  = VECS[i][3];
      supportReq = VECS[i][2];
      @(negedge clk);
      checkAll($sformatf("vec%0d R2 R3 R4", i), VECS[i][1], VECS[i][0]);
    end
    bootPulse = 1'b0; supportReq = 1'b0;

    // Cold reset while exposed is both active and pending
    supportReq = 1'b1; @(negedge clk);
    supportReq = 1'b0; bootPulse = 1'b1; @(negedge clk);
    bootPulse = 1'b0; supportReq = 1'b1; @(negedge clk);
    supportReq = 1'b0;
    checkAll("R2 R3 pre-reset", 1'b1, 1'b1);
    coldRstN = 1'b0;
    #1;
    checkAll("R1 cold reset from exposed", 1'b0, 1'b0);
    @(negedge clk);
    coldRstN = 1'b1;
    bootPulse = 1'b1; @(negedge clk);
    bootPulse = 1'b0;
    checkAll("R9 boot after cold reset", 1'b0, 1'b0);

    // Multiple requests in one boot behave as one
    supportReq = 1'b1; @(negedge clk); @(negedge clk);
    supportReq = 1'b0; @(negedge clk);
    checkAll("R2 repeated request", 1'b0, 1'b1);
    bootPulse = 1'b1; @(negedge clk);
    bootPulse = 1'b0;
    checkAll("R4 rearm after repeated", 1'b1, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule